// File: doc/BRIEF.md
# Paged DMA address generator

This block forms the 24-bit physical memory address for one DMA channel. The upper address bits come from a page value held outside the block. The lower bits come from a 16-bit offset counter that advances once for every accepted transfer. Alongside the offset, a 16-bit down-counter holds the number of transfers still to go, minus one. One input selects the channel type. A byte channel moves one byte per transfer inside a 64 KB page. A word channel moves one 16-bit word per transfer inside a 128 KB page, and the byte address of each word is always even.

Loading a channel writes a base offset and a base count, and this also arms the channel. Each step pulse then issues the current address and advances the counters. The offset wraps inside its page and never carries into the page value. When the final transfer is issued, the block raises a single-cycle terminal pulse. If auto-initialisation is enabled, the channel reloads its base values and carries on. Otherwise it masks itself and ignores later steps. A residue output gives the bytes still to be transferred, so that a host can poll how far the transfer has got.

Top module: `paged_dma_addr_gen`

## Requirements
- R1: With `word_mode_i` low, `phys_addr_o` equals page_i in bits 23..16 and the 16-bit current offset in bits 15..0.
- R2: With `word_mode_i` high, `phys_addr_o` equals page_i bits 7..1 in bits 23..17, the current offset in bits 16..1, and 0 in bit 0. Page bit 0 has no effect on the address.
- R3: Each accepted step adds one to the 16-bit offset. From 0xFFFF the offset wraps to 0x0000, and bits 23..17 of the address (bits 23..16 on a byte channel) keep following the page input only.
- R4: The count holds transfers minus one, so a loaded count of N gives exactly N+1 accepted steps before terminal count. A count of 0xFFFF gives 65536 steps. `tc_o` is high for the one cycle after the step that found the count at 0x0000, and `tc_o` is never high otherwise.
- R5: `residue_o` is (count + 1) mod 65536 on a byte channel and twice that on a word channel. It reads 0 once the last transfer has been issued and no reload took place.
- R6: When terminal count is reached with `auto_init_i` high, the offset and the count return to their loaded base values in the same edge, and the channel stays unmasked.
- R7: When terminal count is reached with `auto_init_i` low, `masked_o` goes high. While `masked_o` is high, step pulses change neither the address nor the residue.
- R8: `load_i` writes the base and current offset and count, clears `masked_o`, and takes priority over a step in the same cycle. Such a step is dropped.
- R9: After reset the offset is 0, the count is 0xFFFF (residue 0), `masked_o` is 1 and `tc_o` is 0.
- R10: `word_size_o` is high exactly when `word_mode_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_mode_i | input | 1 | 1 selects a word channel, 0 selects a byte channel |
| auto_init_i | input | 1 | Reload base values at terminal count |
| page_i | input | 8 | Page value giving the upper address bits |
| load_i | input | 1 | Write base offset and count, and arm the channel |
| base_addr_i | input | 16 | Offset value written by load |
| base_count_i | input | 16 | Transfers minus one, written by load |
| step_i | input | 1 | One transfer issued this cycle |
| phys_addr_o | output | 24 | Physical byte address of the current transfer |
| word_size_o | output | 1 | Transfer size indication, 1 means 16-bit |
| tc_o | output | 1 | Single-cycle terminal-count pulse |
| residue_o | output | 17 | Bytes still to transfer |
| masked_o | output | 1 | Channel stopped; steps are ignored |

## Verification
The bench aims at the offset wrap from 0xFFFF to 0x0000 on both channel types. A design that carried into the page would show a changed upper address after the wrap. A run with the full 65536-transfer count is used to catch an off-by-one in the terminal test, which would show up as a pulse one step early or one step late. On a word channel the bench toggles page bit 0 and expects no change; a design that used that bit, or that reported the residue in words, would differ there. Auto-reload and masking are checked around the terminal step, as is a load that arrives together with a step. A design that let masked steps through would show the address still moving after the stop.

// File: rtl/paged_dma_pkg.sv
package paged_dma_pkg;
  typedef enum logic {
    CH_BYTE = 1'b0,
    CH_WORD = 1'b1
  } ch_size_e;

  typedef struct packed {
    logic adv;
    logic term;
    logic reload;
  } step_ctl_t;
endpackage

// File: rtl/dma_offs_ctr.sv
module dma_offs_ctr #(
  parameter int OFFS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [OFFS_W-1:0] base_i,
  input  logic              adv_i,
  input  logic              reload_i,
  output logic [OFFS_W-1:0] cur_o
);
  logic [OFFS_W-1:0] base_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      cur_q  <= base_i;
    end else if (adv_i) begin
      // wraps inside the page, no carry out
      cur_q <= reload_i ? base_q : cur_q + 1'b1;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/dma_cnt_ctr.sv
module dma_cnt_ctr #(
  parameter int OFFS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [OFFS_W-1:0] base_i,
  input  logic              adv_i,
  input  logic              auto_i,
  output logic [OFFS_W-1:0] cur_o,
  output logic              term_o
);
  logic [OFFS_W-1:0] base_q, cur_q;

  assign term_o = adv_i && (cur_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '1;
      cur_q  <= '1;
    end else if (load_i) begin
      base_q <= base_i;
      cur_q  <= base_i;
    end else if (adv_i) begin
      cur_q <= (term_o && auto_i) ? base_q : cur_q - 1'b1;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map #(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 16,
  localparam int PHYS_W = PAGE_W + OFFS_W,
  localparam int RES_W  = OFFS_W + 1
) (
  input  paged_dma_pkg::ch_size_e size_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [OFFS_W-1:0]       offs_i,
  input  logic [OFFS_W-1:0]       cnt_i,
  output logic [PHYS_W-1:0]       phys_o,
  output logic [RES_W-1:0]        residue_o
);
  logic [OFFS_W-1:0] left;

  // count holds transfers minus one; truncation makes 0xFFFF read as zero
  assign left = cnt_i + 1'b1;

  always_comb begin
    if (size_i == paged_dma_pkg::CH_WORD) begin
      phys_o    = {page_i[PAGE_W-1:1], offs_i, 1'b0};
      residue_o = {left, 1'b0};
    end else begin
      phys_o    = {page_i, offs_i};
      residue_o = {1'b0, left};
    end
  end
endmodule

// File: rtl/paged_dma_addr_gen.sv
module paged_dma_addr_gen #(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 16,
  localparam int PHYS_W = PAGE_W + OFFS_W,
  localparam int RES_W  = OFFS_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_mode_i,
  input  logic              auto_init_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              load_i,
  input  logic [OFFS_W-1:0] base_addr_i,
  input  logic [OFFS_W-1:0] base_count_i,
  input  logic              step_i,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic              word_size_o,
  output logic              tc_o,
  output logic [RES_W-1:0]  residue_o,
  output logic              masked_o
);
  import paged_dma_pkg::*;

  step_ctl_t         ctl;
  ch_size_e          size;
  logic [OFFS_W-1:0] offs, cnt;
  logic              mask_q, tc_q;

  assign size       = word_mode_i ? CH_WORD : CH_BYTE;
  assign ctl.adv    = step_i && !mask_q && !load_i;
  assign ctl.reload = ctl.term && auto_init_i;

  dma_offs_ctr #(.OFFS_W(OFFS_W)) i_offs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .base_i   (base_addr_i),
    .adv_i    (ctl.adv),
    .reload_i (ctl.reload),
    .cur_o    (offs)
  );

  dma_cnt_ctr #(.OFFS_W(OFFS_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .base_i (base_count_i),
    .adv_i  (ctl.adv),
    .auto_i (auto_init_i),
    .cur_o  (cnt),
    .term_o (ctl.term)
  );

  dma_phys_map #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) i_map (
    .size_i    (size),
    .page_i    (page_i),
    .offs_i    (offs),
    .cnt_i     (cnt),
    .phys_o    (phys_addr_o),
    .residue_o (residue_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b1;
      tc_q   <= 1'b0;
    end else begin
      tc_q <= ctl.term;
      if (load_i)                        mask_q <= 1'b0;
      else if (ctl.term && !auto_init_i) mask_q <= 1'b1;
    end
  end

  assign tc_o        = tc_q;
  assign masked_o    = mask_q;
  assign word_size_o = (size == CH_WORD);
endmodule

// File: rtl/paged_dma_addr_gen_chk.sv
module paged_dma_addr_gen_chk #(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 16,
  localparam int PHYS_W = PAGE_W + OFFS_W,
  localparam int RES_W  = OFFS_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_mode_i,
  input logic              auto_init_i,
  input logic [PAGE_W-1:0] page_i,
  input logic              load_i,
  input logic [OFFS_W-1:0] base_addr_i,
  input logic [OFFS_W-1:0] base_count_i,
  input logic              step_i,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic              word_size_o,
  input logic              tc_o,
  input logic [RES_W-1:0]  residue_o,
  input logic              masked_o
);
  logic unused_ok;
  assign unused_ok = ^{base_addr_i, base_count_i};

  AST_WORD_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_mode_i |-> (phys_addr_o[0] == 1'b0)); // R2

  AST_SIZE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_size_o == word_mode_i); // R10

  AST_NO_PAGE_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !masked_o && !load_i) |=>
      (!$stable(page_i) || !$stable(word_mode_i) ||
       phys_addr_o[PHYS_W-1:OFFS_W+1] == $past(phys_addr_o[PHYS_W-1:OFFS_W+1]))); // R3

  AST_TC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> $past(step_i && !masked_o && !load_i)); // R4

  AST_MASK_RESIDUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_o |-> (residue_o == '0)); // R5

  AST_STOP_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !masked_o && !load_i && !auto_init_i &&
     residue_o == (word_mode_i ? RES_W'(2) : RES_W'(1))) |=> masked_o); // R7

  AST_LOAD_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!masked_o && !tc_o)); // R8
endmodule

bind paged_dma_addr_gen paged_dma_addr_gen_chk #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) i_chk (.*);

// File: tb/test_paged_dma_addr_gen.sv
`timescale 1ns/1ps
module test_paged_dma_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b0, auto_init = 1'b0, load = 1'b0, step = 1'b0;
  logic [7:0]  page = 8'h00;
  logic [15:0] base_addr = 16'h0, base_count = 16'h0;
  logic [23:0] phys;
  logic        wsize, tc, masked;
  logic [16:0] residue;

  int n_cmp = 0, n_bad = 0, cyc = 0, tc_seen = 0;

  always #2.5 clk = ~clk;

  paged_dma_addr_gen i_paged_dma_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .word_mode_i(word_mode), .auto_init_i(auto_init),
    .page_i(page), .load_i(load), .base_addr_i(base_addr), .base_count_i(base_count),
    .step_i(step), .phys_addr_o(phys), .word_size_o(wsize), .tc_o(tc),
    .residue_o(residue), .masked_o(masked)
  );

  // behavioural reference
  int m_addr, m_cnt, m_ba, m_bc;
  bit m_mask, m_tc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr <= 0; m_cnt <= 65535; m_ba <= 0; m_bc <= 65535; m_mask <= 1; m_tc <= 0;
    end else if (load) begin
      m_ba <= base_addr; m_bc <= base_count; m_addr <= base_addr; m_cnt <= base_count;
      m_mask <= 0; m_tc <= 0;
    end else if (step && !m_mask) begin
      m_tc <= (m_cnt == 0);
      if (m_cnt == 0 && auto_init) begin
        m_addr <= m_ba; m_cnt <= m_bc;
      end else begin
        m_addr <= (m_addr + 1) % 65536;
        m_cnt  <= (m_cnt + 65535) % 65536;
        if (m_cnt == 0) m_mask <= 1;
      end
    end else begin
      m_tc <= 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      int ep, er;
      if (word_mode) ep = ((int'(page) / 2) * 131072) + m_addr * 2;
      else           ep = int'(page) * 65536 + m_addr;
      er = ((m_cnt + 1) % 65536) * (word_mode ? 2 : 1);
      check(word_mode ? "R2 addr" : "R1 addr", int'(phys), ep);
      check("R5 residue", int'(residue), er);
      check("R4 tc", int'(tc), int'(m_tc));
      check("R7 mask", int'(masked), int'(m_mask));
      check("R10 size", int'(wsize), int'(word_mode));
      if (tc) tc_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(input bit s, input bit l);
    step = s; load = l;
    @(negedge clk);
    step = 0; load = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state, still in reset
    check("R9 addr", int'(phys), 0);
    check("R9 residue", int'(residue), 0);
    check("R9 mask", int'(masked), 1);
    check("R9 tc", int'(tc), 0);
    rst_n = 1;
    @(negedge clk);

    // byte channel, wrap inside page, stop at end (R1 R3 R7)
    page = 8'h12; base_addr = 16'hFFFE; base_count = 16'd3;
    tick(0, 1);
    check("R1 load", int'(phys), 24'h12FFFE);
    check("R5 load", int'(residue), 4);
    tick(1, 0);
    check("R1 step", int'(phys), 24'h12FFFF);
    tick(1, 0);
    check("R3 wrap", int'(phys), 24'h120000);
    tick(1, 0);
    tick(1, 0);
    check("R4 tc", int'(tc), 1);
    check("R7 stop", int'(masked), 1);
    check("R5 zero", int'(residue), 0);
    tick(1, 0);
    check("R7 ignored", int'(phys), 24'h120002);
    check("R4 one cycle", int'(tc), 0);

    // word channel with auto reload (R2 R6)
    word_mode = 1; auto_init = 1; page = 8'h35; base_addr = 16'h1000; base_count = 16'd1;
    tick(0, 1);
    check("R2 load", int'(phys), 24'h342000);
    check("R5 word", int'(residue), 4);
    page = 8'h34;
    @(negedge clk);
    check("R2 page bit0", int'(phys), 24'h342000);
    tick(1, 0);
    check("R2 step", int'(phys), 24'h342002);
    tick(1, 0);
    check("R6 reload addr", int'(phys), 24'h342000);
    check("R6 reload res", int'(residue), 4);
    check("R6 unmasked", int'(masked), 0);

    // word wrap (R3) and load beating step (R8)
    page = 8'h35; base_addr = 16'hFFFF; base_count = 16'd9;
    tick(1, 1);
    check("R8 load wins", int'(phys), 24'h35FFFE);
    check("R8 res", int'(residue), 20);
    tick(1, 0);
    check("R3 word wrap", int'(phys), 24'h340000);

    // full count run, byte channel (R4)
    word_mode = 0; auto_init = 0; page = 8'hA0; base_addr = 16'h0; base_count = 16'hFFFF;
    tick(0, 1);
    tc_seen = 0;
    for (int i = 0; i < 65535; i++) tick(1, 0);
    check("R4 no early tc", tc_seen, 0);
    check("R4 still armed", int'(masked), 0);
    tick(1, 0);
    check("R4 tc at 65536", int'(tc), 1);
    check("R7 masked after", int'(masked), 1);
    tick(0, 1);
    check("R8 unmask", int'(masked), 0);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule